// File: doc/BRIEF.md
# Interrupt Context Shadow Unit

This block keeps a copy of the core's working context across an interrupt. When the core raises the entry strobe, all eight context bytes are captured into shadow registers in a single clock. The eight bytes are the working register, the status byte, the bank select, the program-latch byte and the low and high halves of both pointer registers. The capture needs no software action and cannot be switched off.

When the core raises the leave strobe, the unit latches the shadow contents onto a restore bus. It also pulses a load signal for one cycle, so the core can reload its registers from that bus.

A small register port gives software read and write access to every shadow byte. Software can therefore inspect a saved context, or replace it with another task's context before returning. Address decoding into the special-function space of the top bank is done outside this block. The port sees a 3-bit shadow index.

The restore path is a two-state machine:
- `ST_READY` is the idle state. It moves to `ST_RESTORE` when the leave strobe is high.
- `ST_RESTORE` holds the load pulse for one cycle. It always returns to `ST_READY` on the next clock.

Top module: `ctx_shadow_unit`

## Requirements
- R1: After reset all eight shadows read zero and `restore_o` is low.
- R2: The entry strobe captures all eight bytes of `core_i` into the shadows at the next clock edge. The values captured are those present before that edge. Byte k of `core_i` is bits [8k+7:8k], with index 0 STATUS, 1 FSR0L, 2 FSR0H, 3 FSR1L, 4 FSR1H, 5 BSR, 6 WREG and 7 PCLATH.
- R3: Capture has no enable. Every entry strobe captures, including back-to-back strobes and strobes that arrive while a restore is in progress.
- R4: A leave strobe makes `restore_o` high in the cycle after the edge. In that cycle `restore_data_o` carries the shadow values held just before that edge, using the byte order of R2.
- R5: `restore_o` is high for exactly one cycle per leave strobe.
- R6: A software write with `sw_wr_i` high stores `sw_wdata_i` into the shadow at index `sw_addr_i` (encoding as in R2). No other shadow changes.
- R7: When a software write and an entry strobe occur in the same cycle, the captured core value wins in every shadow.
- R8: Bits 7:5 of the BSR shadow and bit 7 of the PCLATH shadow always read zero, whether the shadow was loaded by capture or by software write.
- R9: `sw_rdata_o` shows the shadow at index `sw_addr_i` in the same cycle, with no register stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enter_i | input | 1 | Interrupt-entry strobe |
| leave_i | input | 1 | Return-from-interrupt strobe |
| core_i | input | 64 | Current core context bytes, index order of R2 |
| sw_wr_i | input | 1 | Software write strobe |
| sw_addr_i | input | 3 | Shadow index for software read and write |
| sw_wdata_i | input | 8 | Software write data |
| sw_rdata_o | output | 8 | Shadow byte at `sw_addr_i` |
| restore_o | output | 1 | One-cycle restore load pulse |
| restore_data_o | output | 64 | Context bytes to reload into the core |

## Verification
A corrupted shadow byte is visible at the read port in the very cycle it is addressed. It is also visible on the restore bus one cycle after the next leave strobe. Both paths are compared against a bench-side model.

A stuck or wrong restore state shows up as a missing, doubled or stretched `restore_o` pulse. The scoreboard flags it at the first negative edge after the leave strobe.

Masking errors on the narrow bytes appear as set pad bits as soon as an all-ones value has been written or captured.

// File: rtl/ctx_pkg.sv
package ctx_pkg;
    localparam int NREG  = 8;
    localparam int IDX_W = $clog2(NREG);

    typedef enum logic [IDX_W-1:0] {
        IX_STATUS = 3'd0,
        IX_FSR0L  = 3'd1,
        IX_FSR0H  = 3'd2,
        IX_FSR1L  = 3'd3,
        IX_FSR1H  = 3'd4,
        IX_BSR    = 3'd5,
        IX_WREG   = 3'd6,
        IX_PCLATH = 3'd7
    } ctx_idx_e;

    typedef enum logic {
        ST_READY   = 1'b0,
        ST_RESTORE = 1'b1
    } leave_state_e;
endpackage

// File: rtl/ctx_shadow_cell.sv
module ctx_shadow_cell #(
    parameter int          DW   = 8,
    parameter logic [DW-1:0] MASK = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_i,
    input  logic [DW-1:0] cap_d,
    input  logic          wr_i,
    input  logic [DW-1:0] wr_d,
    output logic [DW-1:0] q_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q_o <= '0;
        else if (cap_i) q_o <= cap_d & MASK;
        else if (wr_i)  q_o <= wr_d & MASK;
    end

    // R8: pad bits never set
    a_r8_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (q_o & ~MASK) == '0);
endmodule

// File: rtl/ctx_leave_fsm.sv
module ctx_leave_fsm #(
    parameter int BUS_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             leave_i,
    input  logic [BUS_W-1:0] shadow_i,
    output logic             restore_o,
    output logic [BUS_W-1:0] data_o
);
    import ctx_pkg::*;

    leave_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_READY:   if (leave_i) state_d = ST_RESTORE;
            ST_RESTORE: state_d = ST_READY;
            default:    state_d = ST_READY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_READY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       data_o <= '0;
        else if (leave_i) data_o <= shadow_i;
    end

    assign restore_o = (state_q == ST_RESTORE);

    // R5: one-cycle pulse
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        restore_o |=> !restore_o);
    // R4: leave in ready produces a restore next cycle with old shadows
    a_r4_restore_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (leave_i && !restore_o) |=> (restore_o && data_o == $past(shadow_i)));
endmodule

// File: rtl/ctx_shadow_unit.sv
module ctx_shadow_unit #(
    parameter int DW       = 8,
    parameter int BSR_W    = 5,
    parameter int PCLATH_W = 7
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          enter_i,
    input  logic                          leave_i,
    input  logic [ctx_pkg::NREG*DW-1:0]   core_i,
    input  logic                          sw_wr_i,
    input  logic [ctx_pkg::IDX_W-1:0]     sw_addr_i,
    input  logic [DW-1:0]                 sw_wdata_i,
    output logic [DW-1:0]                 sw_rdata_o,
    output logic                          restore_o,
    output logic [ctx_pkg::NREG*DW-1:0]   restore_data_o
);
    import ctx_pkg::*;

    localparam int BUS_W = NREG * DW;

    function automatic logic [DW-1:0] mask_of(int idx);
        if (idx == int'(IX_BSR))    return DW'((1 << BSR_W) - 1);
        if (idx == int'(IX_PCLATH)) return DW'((1 << PCLATH_W) - 1);
        return '1;
    endfunction

    function automatic logic [BUS_W-1:0] mask_bus();
        logic [BUS_W-1:0] m;
        for (int k = 0; k < NREG; k++) m[k*DW +: DW] = mask_of(k);
        return m;
    endfunction

    localparam logic [BUS_W-1:0] MASKS = mask_bus();

    logic [DW-1:0]    shadow_q [NREG];
    logic [BUS_W-1:0] shadow_bus;

    for (genvar g = 0; g < NREG; g++) begin : g_cell
        ctx_shadow_cell #(.DW(DW), .MASK(mask_of(g))) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .cap_i (enter_i),
            .cap_d (core_i[g*DW +: DW]),
            .wr_i  (sw_wr_i && (sw_addr_i == IDX_W'(g))),
            .wr_d  (sw_wdata_i),
            .q_o   (shadow_q[g])
        );
        assign shadow_bus[g*DW +: DW] = shadow_q[g];
    end

    assign sw_rdata_o = shadow_q[sw_addr_i];

    ctx_leave_fsm #(.BUS_W(BUS_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .leave_i   (leave_i),
        .shadow_i  (shadow_bus),
        .restore_o (restore_o),
        .data_o    (restore_data_o)
    );

    // R2 R3 R7: every entry strobe captures, winning over a write
    a_r3_always_capture: assert property (@(posedge clk) disable iff (!rst_n)
        enter_i |=> shadow_bus == ($past(core_i) & MASKS));
    // R6: a lone write changes only the addressed shadow
    a_r6_write_hits: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wr_i && !enter_i) |=>
            shadow_q[$past(sw_addr_i)] == ($past(sw_wdata_i) & mask_of(int'($past(sw_addr_i)))));
    a_r6_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_wr_i && !enter_i) |=> $stable(shadow_bus));
endmodule

// File: tb/tb_ctx_shadow_unit.sv
module tb_ctx_shadow_unit;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        enter_i = 0, leave_i = 0, sw_wr_i = 0;
    logic [63:0] core_i = '0;
    logic [2:0]  sw_addr_i = '0;
    logic [7:0]  sw_wdata_i = '0;
    logic [7:0]  sw_rdata_o;
    logic        restore_o;
    logic [63:0] restore_data_o;

    always #2.5 clk = ~clk;

    ctx_shadow_unit dut (.*);

    int n_chk = 0, n_fail = 0;
    logic [7:0]  model [8];
    logic [63:0] exp_q [$];
    bit          done = 0;

    function automatic logic [7:0] msk(int k);
        return (k == 5) ? 8'h1F : (k == 7) ? 8'h7F : 8'hFF;
    endfunction

    function automatic logic [63:0] model_bus();
        logic [63:0] b;
        for (int k = 0; k < 8; k++) b[k*8 +: 8] = model[k];
        return b;
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic check_all(string req);
        for (int k = 0; k < 8; k++) begin
            sw_addr_i = 3'(k);
            #1;
            check(req, {56'd0, sw_rdata_o}, {56'd0, model[k]});
        end
    endtask

    // Driver tasks: drive at negedge, update model at the edge that follows
    task automatic do_enter(logic [63:0] v, bit with_wr, logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        enter_i = 1; core_i = v; sw_wr_i = with_wr; sw_addr_i = a; sw_wdata_i = d;
        @(negedge clk);
        enter_i = 0; sw_wr_i = 0;
        for (int k = 0; k < 8; k++) model[k] = v[k*8 +: 8] & msk(k);
    endtask

    task automatic do_write(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        sw_wr_i = 1; sw_addr_i = a; sw_wdata_i = d;
        @(negedge clk);
        sw_wr_i = 0;
        model[a] = d & msk(int'(a));
    endtask

    task automatic do_leave();
        @(negedge clk);
        leave_i = 1;
        exp_q.push_back(model_bus());
        @(negedge clk);
        leave_i = 0;
    endtask

    // Monitor: pop expected restore on each pulse (R4, R5)
    always @(negedge clk) begin
        if (rst_n && restore_o) begin
            if (exp_q.size() == 0) check("R5 extra pulse", 64'd1, 64'd0);
            else check("R4 restore data", restore_data_o, exp_q.pop_front());
        end
    end

    initial begin
        for (int k = 0; k < 8; k++) model[k] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 restore low", {63'd0, restore_o}, 64'd0);
        check_all("R1 reset zero");

        do_enter(64'h0807_0605_0403_0201, 0, 0, 0);
        check_all("R2 capture");
        do_leave();
        @(negedge clk);
        check("R5 pulse ended", {63'd0, restore_o}, 64'd0);
        check("R4 queue drained", 64'(exp_q.size()), 64'd0);

        // R3: back-to-back captures and capture during restore
        do_enter(64'h1122_3344_5566_7788, 0, 0, 0);
        do_enter(64'hA1B2_C3D4_E5F6_0718, 0, 0, 0);
        check_all("R3 back-to-back");
        @(negedge clk);
        leave_i = 1; exp_q.push_back(model_bus());
        @(negedge clk);
        leave_i = 0; enter_i = 1; core_i = 64'h5A5A_5A5A_5A5A_5A5A;
        @(negedge clk);
        enter_i = 0;
        for (int k = 0; k < 8; k++) model[k] = 8'h5A & msk(k);
        check_all("R3 capture during restore");

        // R6: write one shadow only
        do_write(3'd6, 8'hC3);
        check_all("R6 single write");
        do_write(3'd0, 8'h99);
        check_all("R6 write status");

        // R8: pad bits
        do_write(3'd5, 8'hFF);
        do_write(3'd7, 8'hFF);
        sw_addr_i = 3'd5; #1;
        check("R8 bsr pad", {56'd0, sw_rdata_o}, 64'h1F);
        sw_addr_i = 3'd7; #1;
        check("R8 pclath pad", {56'd0, sw_rdata_o}, 64'h7F);
        do_enter('1, 0, 0, 0);
        check_all("R8 capture pad");

        // R7: write and capture together
        do_enter(64'h0102_0304_0506_0708, 1, 3'd2, 8'hEE);
        check_all("R7 capture wins");

        // R9: same-cycle read after address change
        sw_addr_i = 3'd4; #1;
        check("R9 comb read", {56'd0, sw_rdata_o}, {56'd0, model[4]});

        // task switch: software replaces context then leaves
        for (int k = 0; k < 8; k++) do_write(3'(k), 8'(8'h30 + k));
        do_leave();
        repeat (2) @(negedge clk);
        check("R4 queue drained", 64'(exp_q.size()), 64'd0);
        check("R5 idle", {63'd0, restore_o}, 64'd0);
        done = 1;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog act=hung exp=done");
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule